// File: doc/BRIEF.md
# Two-Client Fair Arbiter

This block shares one resource between two clients. Each client raises its request line; on every clock edge the arbiter looks at both lines and, in the following cycle, drives at most one grant bit. A grant covers a single cycle. A client that still wants the resource keeps its request high and competes again at the next edge.

Contention is settled by remembering which client won most recently and handing the next contested grant to the other one. This alternation bounds how long a client can wait: once its request goes up, the other client can be granted at most once before the waiting client is served. Each client also has a small saturating counter of grants the other client received while this one was left waiting. The counter is exposed on a port so that an environment can watch the bound directly.

Top module: `duoFairArb`

## Requirements
- R1: While the synchronous active-high reset is high at an edge, the next cycle shows grants 00 and both wait counters at zero. The first contention after reset is won by client 0.
- R2: Both grant bits are never high in the same cycle.
- R3: If exactly one client requests at an edge, that client alone is granted in the next cycle. Grant bit i belongs to client i, so client 0 gets 01 and client 1 gets 10.
- R4: If neither client requests at an edge, the next cycle shows grants 00.
- R5: If both clients request at an edge, the client that was not granted most recently wins. With both requests held, the grant alternates every cycle.
- R6: A grant lasts one cycle. Grant bit i can be high only in a cycle whose preceding cycle had request i high. A held request is arbitrated again at every edge.
- R7: At each edge, wait counter i behaves as follows. It clears if request i is low or grant i is high in that cycle. Otherwise it rises by one (saturating at its all-ones value) if the other client's grant is high. Otherwise it holds.
- R8: Once request i rises and stays high, the other client is not granted twice before client i is granted, and neither wait counter ever exceeds 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 2 | Request lines, bit i from client i |
| gntOut | output | 2 | Registered grants, one-hot or idle |
| waitCnt0 | output | CNT_W | Other-client grants seen while client 0 waits |
| waitCnt1 | output | CNT_W | Other-client grants seen while client 1 waits |

## Verification
Several properties are checked on every cycle outside reset: mutual exclusion of the grants, the tie between each grant and the request before it, the single-requester and idle responses, alternation under held contention, the clearing of the wait counters, and the bound of one foreign grant per waiting window. Some behaviour appears only in the bench's scenarios. These are that client 0 wins the first contention after reset (including a reset in the middle of contention), the exact counter values cycle by cycle, and how priority carries over after single-client and idle stretches.

// File: rtl/duoArbPkg.sv
package duoArbPkg;
  // Decision handed from control to datapath each cycle
  typedef struct packed {
    logic issue;   // some client is granted next cycle
    logic winner;  // index of that client
  } arbStrobe_t;
endpackage

// File: rtl/duoArbCtrl.sv
module duoArbCtrl
  import duoArbPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] reqIn,
  output arbStrobe_t strobe
);
  // lastWin: index of the most recently granted client
  logic lastWin;
  logic pick;

  always_comb begin
    unique case (reqIn)
      2'b01:   pick = 1'b0;
      2'b10:   pick = 1'b1;
      2'b11:   pick = ~lastWin;
      default: pick = lastWin;
    endcase
    strobe.issue  = |reqIn;
    strobe.winner = pick;
  end

  // Reset to 1 so that client 0 wins the first contention
  always_ff @(posedge clk) begin
    if (rst)               lastWin <= 1'b1;
    else if (strobe.issue) lastWin <= strobe.winner;
  end
endmodule

// File: rtl/duoArbDatapath.sv
module duoArbDatapath
  import duoArbPkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            reqIn,
  input  arbStrobe_t            strobe,
  output logic [1:0]            gntQ,
  output logic [1:0][CNT_W-1:0] cntQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar c = 0; c < 2; c++) begin : gClient
    localparam int OTHER = 1 - c;

    always_ff @(posedge clk) begin
      if (rst) gntQ[c] <= 1'b0;
      else     gntQ[c] <= strobe.issue && (strobe.winner == 1'(c));
    end

    always_ff @(posedge clk) begin
      if (rst)                        cntQ[c] <= '0;
      else if (!reqIn[c] || gntQ[c])  cntQ[c] <= '0;
      else if (gntQ[OTHER] && cntQ[c] != CNT_MAX)
                                      cntQ[c] <= cntQ[c] + 1'b1;
    end
  end
endmodule

// File: rtl/duoFairArb.sv
module duoFairArb
  import duoArbPkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reqIn,
  output logic [1:0]       gntOut,
  output logic [CNT_W-1:0] waitCnt0,
  output logic [CNT_W-1:0] waitCnt1
);
  arbStrobe_t            strobe;
  logic [1:0][CNT_W-1:0] cntQ;

  duoArbCtrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .reqIn  (reqIn),
    .strobe (strobe)
  );

  duoArbDatapath #(.CNT_W(CNT_W)) uData (
    .clk    (clk),
    .rst    (rst),
    .reqIn  (reqIn),
    .strobe (strobe),
    .gntQ   (gntOut),
    .cntQ   (cntQ)
  );

  assign waitCnt0 = cntQ[0];
  assign waitCnt1 = cntQ[1];
endmodule

// File: rtl/duoFairArbChk.sv
module duoFairArbChk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reqIn,
  input logic [1:0]       gntOut,
  input logic [CNT_W-1:0] waitCnt0,
  input logic [CNT_W-1:0] waitCnt1
);
  // Independent window tracker: foreign grants since request i rose
  logic [1:0]      prevReq;
  logic [1:0][1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) prevReq <= '0;
    else     prevReq <= reqIn;
  end

  for (genvar c = 0; c < 2; c++) begin : gWin
    always_ff @(posedge clk) begin
      if (rst || !reqIn[c] || gntOut[c]) seen[c] <= '0;
      else if (!prevReq[c])              seen[c] <= {1'b0, gntOut[1-c]};
      else if (gntOut[1-c] && seen[c] != 2'd3) seen[c] <= seen[c] + 2'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (gntOut == 2'b00 && waitCnt0 == '0 && waitCnt1 == '0)); // R1
  AST_GNT_MUTEX: assert property (@(posedge clk) disable iff (rst)
    !(gntOut[0] && gntOut[1])); // R2
  AST_LONE_REQ0: assert property (@(posedge clk) disable iff (rst)
    (reqIn == 2'b01) |=> (gntOut == 2'b01)); // R3
  AST_LONE_REQ1: assert property (@(posedge clk) disable iff (rst)
    (reqIn == 2'b10) |=> (gntOut == 2'b10)); // R3
  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
    (reqIn == 2'b00) |=> (gntOut == 2'b00)); // R4
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (reqIn == 2'b11 && gntOut != 2'b00) |=> (gntOut == ~$past(gntOut))); // R5
  AST_GNT0_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    gntOut[0] |-> $past(reqIn[0])); // R6
  AST_GNT1_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    gntOut[1] |-> $past(reqIn[1])); // R6
  AST_WAIT0_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!reqIn[0] || gntOut[0]) |=> (waitCnt0 == '0)); // R7
  AST_WAIT1_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!reqIn[1] || gntOut[1]) |=> (waitCnt1 == '0)); // R7
  AST_FAIR_0: assert property (@(posedge clk) disable iff (rst)
    seen[0] < 2'd2); // R8
  AST_FAIR_1: assert property (@(posedge clk) disable iff (rst)
    seen[1] < 2'd2); // R8
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (waitCnt0 <= 1 && waitCnt1 <= 1)); // R8
endmodule

bind duoFairArb duoFairArbChk #(.CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .reqIn    (reqIn),
  .gntOut   (gntOut),
  .waitCnt0 (waitCnt0),
  .waitCnt1 (waitCnt1)
);

// File: tb/sim_duoFairArb.sv
module sim_duoFairArb;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reqIn = 2'b00;
  logic [1:0]    gntOut;
  logic [CW-1:0] waitCnt0, waitCnt1;

  always #5 clk = ~clk;

  duoFairArb #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .reqIn(reqIn),
    .gntOut(gntOut), .waitCnt0(waitCnt0), .waitCnt1(waitCnt1)
  );

  typedef struct {
    logic [1:0]    gnt;
    logic [CW-1:0] c0;
    logic [CW-1:0] c1;
    string         tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state (built from the requirements)
  logic          mLast = 1'b1;
  logic [1:0]    mGnt  = 2'b00;
  logic [CW-1:0] mC0 = '0, mC1 = '0;

  function automatic logic [CW-1:0] nextCnt(logic r, logic g, logic go, logic [CW-1:0] c);
    if (!r || g) return '0;        // R7 clear
    if (go && c != '1) return c + 1'b1;
    return c;
  endfunction

  // Driver: applies one cycle of stimulus and queues what the next cycle must show
  task automatic step(input logic rv, input logic [1:0] r, input string tag);
    expItem_t e;
    logic [1:0] ng;
    @(negedge clk);
    rst = rv;
    reqIn = r;
    if (rv) begin
      e.gnt = 2'b00; e.c0 = '0; e.c1 = '0; mLast = 1'b1;
    end else begin
      e.c0 = nextCnt(r[0], mGnt[0], mGnt[1], mC0);
      e.c1 = nextCnt(r[1], mGnt[1], mGnt[0], mC1);
      case (r)
        2'b01:   ng = 2'b01;
        2'b10:   ng = 2'b10;
        2'b11:   ng = mLast ? 2'b01 : 2'b10;
        default: ng = 2'b00;
      endcase
      if (ng != 2'b00) mLast = ng[1];
      e.gnt = ng;
    end
    e.tag = tag;
    q.push_back(e);
    mGnt = e.gnt; mC0 = e.c0; mC1 = e.c1;
  endtask

  // Monitor: compares each queued expectation after the edge it belongs to
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (gntOut !== e.gnt || waitCnt0 !== e.c0 || waitCnt1 !== e.c1) begin
          errors++;
          $display("FAIL %s: gnt=%b cnt0=%0d cnt1=%0d expected gnt=%b cnt0=%0d cnt1=%0d",
                   e.tag, gntOut, waitCnt0, waitCnt1, e.gnt, e.c0, e.c1);
        end
        if (gntOut === 2'b11) begin  // R2 mutual exclusion
          errors++;
          $display("FAIL R2: gnt=%b expected not 11", gntOut);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset clears grants and counters, even with requests pending
    step(1, 2'b11, "R1");
    step(1, 2'b00, "R1");
    // R1 client 0 wins first contention; R5 alternation; R7 counters
    step(0, 2'b11, "R1");
    for (int i = 0; i < 6; i++) step(0, 2'b11, "R5");
    step(0, 2'b11, "R7");
    step(0, 2'b11, "R2");
    // R4 idle
    step(0, 2'b00, "R4");
    step(0, 2'b00, "R4");
    // R3 and R6 single requester, held request re-competes
    for (int i = 0; i < 3; i++) step(0, 2'b01, "R3");
    for (int i = 0; i < 3; i++) step(0, 2'b10, "R6");
    // R8 client 0 rises while client 1 is being served
    step(0, 2'b11, "R8");
    step(0, 2'b11, "R8");
    step(0, 2'b11, "R8");
    // R7 waiting client drops request: counter clears
    step(0, 2'b10, "R7");
    step(0, 2'b11, "R7");
    step(0, 2'b10, "R7");
    step(0, 2'b10, "R7");
    // R8 client 1 rises while client 0 holds
    step(0, 2'b01, "R8");
    step(0, 2'b11, "R8");
    step(0, 2'b11, "R8");
    // R5 priority survives an idle gap: last winner loses next contention
    step(0, 2'b00, "R5");
    step(0, 2'b11, "R5");
    step(0, 2'b11, "R5");
    // R1 reset in the middle of contention restores client 0 priority
    step(1, 2'b11, "R1");
    step(0, 2'b11, "R1");
    step(0, 2'b11, "R1");
    step(0, 2'b00, "R4");
    step(0, 2'b00, "R4");
    while (q.size() > 0) @(posedge clk);
    #3;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule